// File: doc/BRIEF.md
# Flash Command Register Front End

This block sits between a 32-bit register bus and a behavioural on-chip flash array. Software unlocks it with a two-word key, loads a control word selecting sector erase, mass erase or programming, and then either sets a start bit or writes data into the array window. The block checks each request against the lock state, the busy state, the programming width, the address alignment and per-sector write-protect inputs. It then either issues a one-cycle request to the array port or records an error flag.

The bus has one address space split by its top address bit. With that bit clear, word offset 0x0 is the key register, 0x4 the control register and 0x8 the status register. With it set, the lower 20 bits are a byte offset into a 1 MB array. The array is divided into twelve sectors: four of 16 KB, then one of 64 KB, then seven of 128 KB. Reads return through a registered read-data port one cycle after the access. Status error flags stay set until software writes 1 to them.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the control register reads 0x80000000 (bit 31 = locked, all other fields zero), the status register reads 0, and no array request is issued.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the key register unlocks the block, and control then reads with bit 31 clear. While the block is locked, control writes have no effect.
- R3: A control write with bit 31 set relocks the block at once. Later control writes are ignored until both keys are written again.
- R4: A key write that does not match the expected key while locked sets status bit 1. After that no key sequence unlocks the block until reset.
- R5: Control fields are: bit 0 program enable, bit 1 sector erase, bit 2 mass erase, bits 6:3 sector number, bits 9:8 program size, bit 16 start (reads 0). A control write with sector erase, start and a sector number below 12 issues arr_cmd=1 with that sector. Sector numbers 12 to 15, or sector and mass erase together, set status bit 7 instead.
- R6: A control write with mass erase and start issues arr_cmd=2.
- R7: With program enable set, an array-window write issues arr_cmd=3 carrying the byte offset, data and size. Status bit 16 (busy) is set from the request until arr_done is seen.
- R8: An array-window write while locked or while program enable is clear sets status bit 7 and issues no request.
- R9: Bus access size and program size are both encoded as 0=8, 1=16, 2=32 and 3=64 bits. A program write whose access size differs from the program size sets status bit 6. An offset not aligned to the program size sets status bit 5. Neither write issues a request.
- R10: An erase or program aimed at a sector whose wp_sector bit is high sets status bit 4 and issues no request. Mass erase counts as aimed at every sector.
- R11: Writing 1 to status bits 7, 6, 5, 4 or 1 clears those bits, and writing 0 leaves them unchanged. Error bits and the busy bit are reported together.
- R12: A start or program write made while busy sets status bit 7 and is dropped.
- R13: Program offsets map to sectors as follows: below 0x10000 the sector is offset/16K, from 0x10000 to 0x1FFFF it is sector 4, and from 0x20000 upward it is 5 + (offset-0x20000)/128K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 21 | Bit 20 selects array window, else register offset |
| bus_size | input | 2 | Access width of array writes |
| bus_wdata | input | 64 | Write data; registers use bits 31:0 |
| bus_rdata | output | 32 | Registered read data |
| wp_sector | input | 12 | Per-sector write protect |
| arr_req | output | 1 | One-cycle array operation request |
| arr_cmd | output | 2 | 1 sector erase, 2 mass erase, 3 program |
| arr_sector | output | 4 | Target sector |
| arr_addr | output | 20 | Program byte offset |
| arr_data | output | 64 | Program data |
| arr_psize | output | 2 | Program width |
| arr_done | input | 1 | Array finished the current operation |

## Verification
The hardest state to reach is a busy controller that is also holding an error flag. This takes an accepted program followed by a second program write before the array reports completion. The bench therefore holds arr_done low and issues the second write, then reads status while busy is still high and expects the busy bit and the sequence bit together. The permanently blocked key state can only be left by reset, so it is exercised last and followed by a reset and a fresh unlock.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
  localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;

  localparam int CB_PG    = 0;
  localparam int CB_SER   = 1;
  localparam int CB_MER   = 2;
  localparam int CB_SNB_LO = 3;
  localparam int CB_PSZ_LO = 8;
  localparam int CB_START = 16;
  localparam int CB_LOCK  = 31;

  localparam int SB_BUSY = 16;
  localparam int NUM_ERR = 5;

  typedef enum logic [1:0] {
    ACMD_NONE  = 2'd0,
    ACMD_SECT  = 2'd1,
    ACMD_MASS  = 2'd2,
    ACMD_PROG  = 2'd3
  } arr_cmd_e;

  typedef enum logic [1:0] {
    LK_SHUT   = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2,
    LK_JAMMED = 2'd3
  } lock_st_e;

  function automatic int err_bit_pos(int idx);
    case (idx)
      0: return 7;
      1: return 6;
      2: return 5;
      3: return 4;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/fc_key_lock.sv
module fc_key_lock
  import flash_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        key_wr,
  input  logic [31:0] key_val,
  input  logic        relock,
  output logic        unlocked,
  output logic        bad_key
);
  lock_st_e st;

  assign unlocked = (st == LK_OPEN);

  always_comb begin
    bad_key = 1'b0;
    if (key_wr) begin
      if (st == LK_SHUT && key_val != KEY_FIRST) bad_key = 1'b1;
      if (st == LK_HALF && key_val != KEY_SECOND) bad_key = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= LK_SHUT;
    end else begin
      case (st)
        LK_SHUT:   if (key_wr) st <= (key_val == KEY_FIRST) ? LK_HALF : LK_JAMMED;
        LK_HALF:   if (key_wr) st <= (key_val == KEY_SECOND) ? LK_OPEN : LK_JAMMED;
        LK_OPEN:   if (relock) st <= LK_SHUT;
        default:   st <= LK_JAMMED;
      endcase
    end
  end

  assert_open_after_key2_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(key_wr && key_val == KEY_SECOND));

  assert_relock_now_R3: assert property (@(posedge clk) disable iff (rst)
    (unlocked && relock) |=> !unlocked);

  assert_bad_key_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    bad_key |=> !unlocked);
endmodule

// File: rtl/fc_sector_map.sv
module fc_sector_map #(
  parameter int OFF_W       = 20,
  parameter int SECT_W      = 4,
  parameter int SMALL_BYTES = 16384,
  parameter int SMALL_CNT   = 4,
  parameter int MID_BYTES   = 65536,
  parameter int BIG_BYTES   = 131072
) (
  input  logic [OFF_W-1:0]  offset,
  output logic [SECT_W-1:0] sector
);
  localparam int SMALL_SH  = $clog2(SMALL_BYTES);
  localparam int BIG_SH    = $clog2(BIG_BYTES);
  localparam int SMALL_END = SMALL_BYTES * SMALL_CNT;
  localparam int MID_END   = SMALL_END + MID_BYTES;

  logic [31:0] off32;
  logic [31:0] rel;
  logic [31:0] small_idx;
  logic [31:0] big_idx;

  always_comb begin
    off32     = 32'(offset);
    rel       = off32 - 32'(MID_END);
    small_idx = off32 >> SMALL_SH;
    big_idx   = 32'(SMALL_CNT + 1) + (rel >> BIG_SH);
    if (off32 < 32'(SMALL_END))    sector = SECT_W'(small_idx);
    else if (off32 < 32'(MID_END)) sector = SECT_W'(SMALL_CNT);
    else                           sector = SECT_W'(big_idx);
  end
endmodule

// File: rtl/fc_op_seq.sv
module fc_op_seq
  import flash_cmd_pkg::*;
#(
  parameter int OFF_W       = 20,
  parameter int SECT_W      = 4,
  parameter int NSECT       = 12,
  parameter int DW          = 64,
  parameter int SMALL_BYTES = 16384,
  parameter int SMALL_CNT   = 4,
  parameter int MID_BYTES   = 65536,
  parameter int BIG_BYTES   = 131072
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              unlocked,
  input  logic              ctrl_wr,
  input  logic              new_ser,
  input  logic              new_mer,
  input  logic [SECT_W-1:0] new_snb,
  input  logic              new_start,
  input  logic              prog_wr,
  input  logic [OFF_W-1:0]  prog_off,
  input  logic [1:0]        prog_size,
  input  logic [DW-1:0]     prog_data,
  input  logic              cur_pg,
  input  logic [1:0]        cur_psize,
  input  logic [NSECT-1:0]  wp,
  input  logic              arr_done,
  output logic              busy,
  output logic              arr_req,
  output arr_cmd_e          arr_cmd,
  output logic [SECT_W-1:0] arr_sector,
  output logic [OFF_W-1:0]  arr_addr,
  output logic [DW-1:0]     arr_data,
  output logic [1:0]        arr_psize,
  output logic              set_seq,
  output logic              set_par,
  output logic              set_aln,
  output logic              set_wrp
);
  localparam int SPAN = 1 << SECT_W;

  logic [SPAN-1:0]   wp_ext;
  logic [SECT_W-1:0] prog_sec;
  logic [OFF_W-1:0]  amask;
  logic              erase_try;
  logic              go_erase;
  logic              go_prog;
  logic              bad_width;
  logic              bad_align;
  logic              prot_prog;

  assign wp_ext = SPAN'(wp);

  fc_sector_map #(
    .OFF_W(OFF_W), .SECT_W(SECT_W), .SMALL_BYTES(SMALL_BYTES),
    .SMALL_CNT(SMALL_CNT), .MID_BYTES(MID_BYTES), .BIG_BYTES(BIG_BYTES)
  ) u_map (
    .offset(prog_off),
    .sector(prog_sec)
  );

  always_comb begin
    amask     = OFF_W'((32'd1 << cur_psize) - 32'd1);
    bad_width = (prog_size != cur_psize);
    bad_align = ((prog_off & amask) != '0);
    prot_prog = wp_ext[prog_sec];
    erase_try = ctrl_wr && unlocked && new_start && (new_ser || new_mer);
    set_seq   = 1'b0;
    set_par   = 1'b0;
    set_aln   = 1'b0;
    set_wrp   = 1'b0;
    go_erase  = 1'b0;
    go_prog   = 1'b0;
    if (erase_try) begin
      if (busy || (new_ser && new_mer) || (new_ser && 32'(new_snb) >= NSECT))
        set_seq = 1'b1;
      else if ((new_ser && wp_ext[new_snb]) || (new_mer && (|wp)))
        set_wrp = 1'b1;
      else
        go_erase = 1'b1;
    end
    if (prog_wr) begin
      if (!unlocked || !cur_pg || busy) begin
        set_seq = 1'b1;
      end else begin
        set_par = bad_width;
        set_aln = bad_align;
        if (prot_prog) set_wrp = 1'b1;
        go_prog = !(bad_width || bad_align || prot_prog);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      arr_req    <= 1'b0;
      arr_cmd    <= ACMD_NONE;
      arr_sector <= '0;
      arr_addr   <= '0;
      arr_data   <= '0;
      arr_psize  <= '0;
    end else begin
      arr_req <= 1'b0;
      if (go_erase) begin
        busy       <= 1'b1;
        arr_req    <= 1'b1;
        arr_cmd    <= new_mer ? ACMD_MASS : ACMD_SECT;
        arr_sector <= new_mer ? '0 : new_snb;
        arr_addr   <= '0;
      end else if (go_prog) begin
        busy       <= 1'b1;
        arr_req    <= 1'b1;
        arr_cmd    <= ACMD_PROG;
        arr_sector <= prog_sec;
        arr_addr   <= prog_off;
        arr_data   <= prog_data;
        arr_psize  <= cur_psize;
      end else if (busy && arr_done) begin
        busy <= 1'b0;
      end
    end
  end

  assert_req_single_R5: assert property (@(posedge clk) disable iff (rst)
    arr_req |=> !arr_req);

  assert_busy_until_done_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !arr_done) |=> busy);

  assert_req_needs_unlock_R8: assert property (@(posedge clk) disable iff (rst)
    arr_req |-> $past(unlocked));

  assert_no_start_while_busy_R12: assert property (@(posedge clk) disable iff (rst)
    arr_req |-> !$past(busy));

  assert_no_req_on_error_R9: assert property (@(posedge clk) disable iff (rst)
    (set_par || set_aln || set_wrp) |=> !arr_req);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int SMALL_BYTES = 16384,
  parameter int SMALL_CNT   = 4,
  parameter int MID_BYTES   = 65536,
  parameter int BIG_BYTES   = 131072,
  parameter int BIG_CNT     = 7,
  parameter int DW          = 64,
  parameter int NSECT       = SMALL_CNT + 1 + BIG_CNT,
  parameter int SECT_W      = 4,
  parameter int ARR_OFF_W   = $clog2(SMALL_BYTES*SMALL_CNT + MID_BYTES + BIG_BYTES*BIG_CNT),
  parameter int ADDR_W      = ARR_OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DW-1:0]     bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSECT-1:0]  wp_sector,
  output logic              arr_req,
  output logic [1:0]        arr_cmd,
  output logic [SECT_W-1:0] arr_sector,
  output logic [ARR_OFF_W-1:0] arr_addr,
  output logic [DW-1:0]     arr_data,
  output logic [1:0]        arr_psize,
  input  logic              arr_done
);
  localparam logic [1:0] RI_KEY  = 2'd0;
  localparam logic [1:0] RI_CTRL = 2'd1;
  localparam logic [1:0] RI_STAT = 2'd2;

  logic       in_window;
  logic [1:0] reg_idx;
  logic       key_wr, ctrl_wr, stat_wr, arr_wr, rd_en;
  logic       unlocked, bad_key, busy, ctrl_take, relock;
  logic       set_seq, set_par, set_aln, set_wrp;
  logic [NUM_ERR-1:0] err_set;
  logic [NUM_ERR-1:0] err_q;
  arr_cmd_e   cmd_enum;

  logic              c_pg, c_ser, c_mer;
  logic [SECT_W-1:0] c_snb;
  logic [1:0]        c_psize;

  assign in_window = bus_addr[ADDR_W-1];
  assign reg_idx   = bus_addr[3:2];
  assign key_wr    = bus_sel && bus_we && !in_window && reg_idx == RI_KEY;
  assign ctrl_wr   = bus_sel && bus_we && !in_window && reg_idx == RI_CTRL;
  assign stat_wr   = bus_sel && bus_we && !in_window && reg_idx == RI_STAT;
  assign arr_wr    = bus_sel && bus_we && in_window;
  assign rd_en     = bus_sel && !bus_we;
  assign ctrl_take = ctrl_wr && unlocked && !busy;
  assign relock    = ctrl_take && bus_wdata[CB_LOCK];

  fc_key_lock u_lock (
    .clk(clk), .rst(rst),
    .key_wr(key_wr), .key_val(bus_wdata[31:0]), .relock(relock),
    .unlocked(unlocked), .bad_key(bad_key)
  );

  fc_op_seq #(
    .OFF_W(ARR_OFF_W), .SECT_W(SECT_W), .NSECT(NSECT), .DW(DW),
    .SMALL_BYTES(SMALL_BYTES), .SMALL_CNT(SMALL_CNT),
    .MID_BYTES(MID_BYTES), .BIG_BYTES(BIG_BYTES)
  ) u_seq (
    .clk(clk), .rst(rst), .unlocked(unlocked),
    .ctrl_wr(ctrl_wr),
    .new_ser(bus_wdata[CB_SER]), .new_mer(bus_wdata[CB_MER]),
    .new_snb(bus_wdata[CB_SNB_LO +: SECT_W]), .new_start(bus_wdata[CB_START]),
    .prog_wr(arr_wr), .prog_off(bus_addr[ARR_OFF_W-1:0]),
    .prog_size(bus_size), .prog_data(bus_wdata),
    .cur_pg(c_pg), .cur_psize(c_psize),
    .wp(wp_sector), .arr_done(arr_done),
    .busy(busy), .arr_req(arr_req), .arr_cmd(cmd_enum),
    .arr_sector(arr_sector), .arr_addr(arr_addr), .arr_data(arr_data),
    .arr_psize(arr_psize),
    .set_seq(set_seq), .set_par(set_par), .set_aln(set_aln), .set_wrp(set_wrp)
  );

  assign arr_cmd = cmd_enum;
  assign err_set = {bad_key, set_wrp, set_aln, set_par, set_seq};

  always_ff @(posedge clk) begin
    if (rst) begin
      c_pg    <= 1'b0;
      c_ser   <= 1'b0;
      c_mer   <= 1'b0;
      c_snb   <= '0;
      c_psize <= '0;
    end else if (ctrl_take) begin
      c_pg    <= bus_wdata[CB_PG];
      c_ser   <= bus_wdata[CB_SER];
      c_mer   <= bus_wdata[CB_MER];
      c_snb   <= bus_wdata[CB_SNB_LO +: SECT_W];
      c_psize <= bus_wdata[CB_PSZ_LO +: 2];
    end
  end

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_err
    localparam int POS = err_bit_pos(g);
    always_ff @(posedge clk) begin
      if (rst)                              err_q[g] <= 1'b0;
      else if (err_set[g])                  err_q[g] <= 1'b1;
      else if (stat_wr && bus_wdata[POS])   err_q[g] <= 1'b0;
    end
  end

  logic [31:0] ctrl_view, stat_view;
  always_comb begin
    ctrl_view = '0;
    ctrl_view[CB_LOCK]             = !unlocked;
    ctrl_view[CB_PSZ_LO +: 2]      = c_psize;
    ctrl_view[CB_SNB_LO +: SECT_W] = c_snb;
    ctrl_view[CB_MER]              = c_mer;
    ctrl_view[CB_SER]              = c_ser;
    ctrl_view[CB_PG]               = c_pg;
    stat_view = '0;
    stat_view[SB_BUSY] = busy;
    for (int i = 0; i < NUM_ERR; i++) stat_view[err_bit_pos(i)] = err_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_en) begin
      case (reg_idx)
        RI_CTRL: bus_rdata <= ctrl_view;
        RI_STAT: bus_rdata <= stat_view;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assert_w1c_seq_R11: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && bus_wdata[7] && !set_seq) |=> !err_q[0]);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (err_q[0] && !stat_wr) |=> err_q[0]);

  assert_locked_ctrl_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !unlocked) |=> $stable(c_pg) && $stable(c_psize));
endmodule

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [20:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [63:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] wp_sector = '0;
  logic        arr_req;
  logic [1:0]  arr_cmd;
  logic [3:0]  arr_sector;
  logic [19:0] arr_addr;
  logic [63:0] arr_data;
  logic [1:0]  arr_psize;
  logic        arr_done = 1'b0;

  int checks = 0;
  int fails = 0;
  int req_cnt = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wp_sector(wp_sector), .arr_req(arr_req),
    .arr_cmd(arr_cmd), .arr_sector(arr_sector), .arr_addr(arr_addr),
    .arr_data(arr_data), .arr_psize(arr_psize), .arr_done(arr_done)
  );

  always @(negedge clk) if (!rst && arr_req) req_cnt++;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [20:0] a, logic [63:0] d, logic [1:0] sz);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [20:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic prog(logic [19:0] off, logic [63:0] d, logic [1:0] sz);
    wr({1'b1, off}, d, sz);
  endtask

  task automatic done_pulse();
    @(negedge clk); arr_done = 1'b1;
    @(negedge clk); arr_done = 1'b0;
  endtask

  task automatic unlock();
    wr(21'h0, 64'h4567_0123, 2'd2);
    wr(21'h0, 64'hCDEF_89AB, 2'd2);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(21'h4, v); chk("R1 ctrl reset", v, 32'h8000_0000);
    rd(21'h8, v); chk("R1 status reset", v, 32'h0);
    chk("R1 no request", req_cnt, 0);
  endtask

  task automatic t_locked();
    logic [31:0] v;
    wr(21'h4, 64'h0000_0101, 2'd2);
    rd(21'h4, v); chk("R2 locked ctrl write ignored", v, 32'h8000_0000);
    prog(20'h10, 64'h55, 2'd0);
    rd(21'h8, v); chk("R8 array write while locked", v, 32'h80);
    chk("R8 no request when locked", req_cnt, 0);
    wr(21'h8, 64'h80, 2'd2);
    rd(21'h8, v); chk("R11 w1c clears seq", v, 32'h0);
  endtask

  task automatic t_unlock();
    logic [31:0] v;
    unlock();
    rd(21'h4, v); chk("R2 unlocked", v, 32'h0);
    wr(21'h4, 64'h0000_0101, 2'd2);
    rd(21'h4, v); chk("R2 ctrl write taken", v, 32'h0000_0101);
  endtask

  task automatic t_program();
    logic [31:0] v;
    int base;
    base = req_cnt;
    prog(20'h10, 64'h1122_3344_5566_BEEF, 2'd1);
    chk("R7 req", arr_req, 1);
    chk("R7 cmd", arr_cmd, 3);
    chk("R7 addr", arr_addr, 20'h10);
    chk("R7 data", arr_data, 64'h1122_3344_5566_BEEF);
    chk("R7 psize", arr_psize, 1);
    rd(21'h8, v); chk("R7 busy", v, 32'h0001_0000);
    prog(20'h12, 64'h1, 2'd1);
    rd(21'h8, v); chk("R12 busy with seq error", v, 32'h0001_0080);
    chk("R12 dropped", req_cnt, base + 1);
    done_pulse();
    rd(21'h8, v); chk("R11 busy cleared error kept", v, 32'h80);
    wr(21'h8, 64'h0, 2'd2);
    rd(21'h8, v); chk("R11 write zero keeps", v, 32'h80);
    wr(21'h8, 64'hF2, 2'd2);
  endtask

  task automatic t_width_align();
    logic [31:0] v;
    int base;
    base = req_cnt;
    prog(20'h20, 64'h7, 2'd2);
    rd(21'h8, v); chk("R9 width mismatch", v, 32'h40);
    wr(21'h8, 64'h40, 2'd2);
    prog(20'h21, 64'h7, 2'd1);
    rd(21'h8, v); chk("R9 misaligned", v, 32'h20);
    wr(21'h8, 64'h20, 2'd2);
    chk("R9 no request", req_cnt, base);
  endtask

  task automatic t_sectors();
    logic [31:0] v;
    int base;
    prog(20'h0C000, 64'h3, 2'd1);
    chk("R13 sector 3", arr_sector, 3); done_pulse();
    prog(20'h20000, 64'h5, 2'd1);
    chk("R13 sector 5", arr_sector, 5); done_pulse();
    prog(20'hFFFFE, 64'hB, 2'd1);
    chk("R13 sector 11", arr_sector, 11); done_pulse();
    wp_sector = 12'h010;
    base = req_cnt;
    prog(20'h10000, 64'h4, 2'd1);
    rd(21'h8, v); chk("R10 protected program", v, 32'h10);
    chk("R10 no request", req_cnt, base);
    wr(21'h8, 64'h10, 2'd2);
  endtask

  task automatic t_erase();
    logic [31:0] v;
    int base;
    wr(21'h4, 64'h0001_003A, 2'd2);
    chk("R5 sector erase cmd", arr_cmd, 1);
    chk("R5 sector erase sector", arr_sector, 7);
    rd(21'h8, v); chk("R5 busy during erase", v, 32'h0001_0000);
    done_pulse();
    base = req_cnt;
    wr(21'h4, 64'h0001_0022, 2'd2);
    rd(21'h8, v); chk("R10 protected sector erase", v, 32'h10);
    wr(21'h8, 64'h10, 2'd2);
    wr(21'h4, 64'h0001_0062, 2'd2);
    rd(21'h8, v); chk("R5 sector 12 invalid", v, 32'h80);
    wr(21'h8, 64'h80, 2'd2);
    wr(21'h4, 64'h0001_0004, 2'd2);
    rd(21'h8, v); chk("R10 mass erase protected", v, 32'h10);
    wr(21'h8, 64'h10, 2'd2);
    chk("R10 no erase request", req_cnt, base);
    wp_sector = '0;
    wr(21'h4, 64'h0001_0004, 2'd2);
    chk("R6 mass erase cmd", arr_cmd, 2);
    chk("R6 mass erase req", arr_req, 1);
    done_pulse();
    base = req_cnt;
    prog(20'h40, 64'h9, 2'd0);
    rd(21'h8, v); chk("R8 program enable clear", v, 32'h80);
    chk("R8 no request pg clear", req_cnt, base);
    wr(21'h8, 64'h80, 2'd2);
  endtask

  task automatic t_relock();
    logic [31:0] v;
    wr(21'h4, 64'h8000_0000, 2'd2);
    rd(21'h4, v); chk("R3 relocked", v, 32'h8000_0000);
    wr(21'h4, 64'h0000_0001, 2'd2);
    rd(21'h4, v); chk("R3 write after relock ignored", v, 32'h8000_0000);
    unlock();
    rd(21'h4, v); chk("R2 unlock again", v, 32'h0);
    wr(21'h4, 64'h8000_0000, 2'd2);
  endtask

  task automatic t_jam();
    logic [31:0] v;
    wr(21'h0, 64'h1234_5678, 2'd2);
    rd(21'h8, v); chk("R4 bad key flag", v, 32'h2);
    unlock();
    rd(21'h4, v); chk("R4 stays locked", v, 32'h8000_0000);
    wr(21'h8, 64'h2, 2'd2);
    rd(21'h8, v); chk("R11 clear op error", v, 32'h0);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    unlock();
    rd(21'h4, v); chk("R4 reset restores unlock", v, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_locked();
    t_unlock();
    t_program();
    t_width_align();
    t_sectors();
    t_erase();
    t_relock();
    t_jam();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule